// File: doc/BRIEF.md
# PLL Reconfiguration Go Sequencer

This block applies a new divider and multiplier setting to a display-link PLL. Software loads the reference pre-divider, the feedback multiplier and the high-speed output divider into staging registers, then raises a single-cycle request that sets the GO flag. On the matching event, the block copies all staged fields at once into the shadow registers that drive the PLL. It then plays out the reload waveform on three PLL pins: an active-low initialise pulse, an enable, and a divider enable. The divider enable also reaches the high-speed output divider, so that divider takes its new setting in the same pass. The block waits for lock and finally drops GO.

A mode input chooses between two timings. In manual mode (mode input 0) the waveform starts in the cycle after the request, and the clock-input enable, divider bypass and reference enable simply mirror their software copies. In automatic mode (mode input 1) both the shadow transfer and the waveform wait for a front-porch strobe from the display controller. In this mode the block owns the three clock controls. It gates the clock input and bypasses the divider while the PLL relocks, then restores them. A lock timeout ends a sequence that never locks and raises a sticky error.

Top module: `pll_go_seq`

## Requirements
- R1: After reset, go_bit, busy and lock_err are 0, pll_init_n is 1, pll_en and pll_div_en are 0, and every shadow field reads 0.
- R2: With the mode input at 0, a go_set pulse accepted while busy is 0 makes go_bit and busy read 1 in the next cycle. In that same cycle pll_init_n is 0 and the shadow fields equal the staged values.
- R3: pll_init_n stays low for exactly T_INIT cycles. pll_en alone is then high for exactly T_EN cycles, after which pll_div_en rises while pll_en stays high. Neither enable is high while pll_init_n is low.
- R4: With the mode input at 1, an accepted go_set leaves pll_init_n high and the shadow fields unchanged until fp_strobe is seen. In the cycle after the strobe, pll_init_n is 0 and the shadow fields hold the staged values.
- R5: A go_set pulse or staging write made while busy is 1 neither restarts the running sequence nor alters the shadow fields. The new staged values reach the shadow only through the next accepted go_set.
- R6: Once lock is reported, go_bit and busy return to 0 while pll_en and pll_div_en remain 1.
- R7: If lock is not reported within LOCK_TMO cycles of the lock wait, the sequence ends. busy is then high for T_INIT+T_EN+T_DIV+LOCK_TMO+1 cycles in total, go_bit clears and lock_err becomes 1. lock_err holds until the next accepted go_set clears it.
- R8: In manual mode, clkin_en, div_bypass and ref_en equal sw_clkin_en, sw_div_bypass and sw_ref_en.
- R9: In automatic mode, ref_en is 1 whatever sw_ref_en is. From the first cycle of pll_init_n low until lock, clkin_en is 0 and div_bypass is 1. At all other times clkin_en is 1 and div_bypass is 0, whatever the software copies hold.
- R10: Staging writes made while busy is 0 do not change the shadow fields until a go_set pulse is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stg_we | input | 1 | Write strobe for the staging registers |
| stg_mult | input | MULT_W | Feedback multiplier value to stage |
| stg_prediv | input | PREDIV_W | Reference pre-divider value to stage |
| stg_hsdiv | input | HSDIV_W | High-speed output divider value to stage |
| go_set | input | 1 | Single-cycle request that sets GO |
| auto_mode | input | 1 | 0 selects manual mode, 1 selects automatic mode |
| fp_strobe | input | 1 | Front-porch event from the display controller |
| pll_lock | input | 1 | Lock indication from the PLL, may be asynchronous |
| sw_clkin_en | input | 1 | Software copy of clock-input enable |
| sw_div_bypass | input | 1 | Software copy of divider bypass |
| sw_ref_en | input | 1 | Software copy of reference enable |
| go_bit | output | 1 | GO flag, cleared by hardware at the end of the sequence |
| busy | output | 1 | A sequence is in progress |
| lock_err | output | 1 | Sticky lock-timeout flag |
| pll_init_n | output | 1 | Active-low PLL initialise pin |
| pll_en | output | 1 | PLL enable pin |
| pll_div_en | output | 1 | Divider enable pin, shared with the high-speed divider |
| shd_mult | output | MULT_W | Shadow multiplier driving the PLL |
| shd_prediv | output | PREDIV_W | Shadow pre-divider driving the PLL |
| shd_hsdiv | output | HSDIV_W | Shadow high-speed divider setting |
| clkin_en | output | 1 | Effective clock-input enable |
| div_bypass | output | 1 | Effective high-speed divider bypass |
| ref_en | output | 1 | Effective reference enable |

## Verification
The assertions assume that go_set is a single-cycle pulse and that the mode input stays steady from a request until busy falls. They also assume fp_strobe is only meaningful while the block waits for it, and that pll_lock has no effect outside the lock wait. The bench keeps to these rules. It changes auto_mode only while busy is 0. It pulses go_set and fp_strobe for exactly one cycle, away from the clock edge. It raises pll_lock only after pll_div_en is seen, and drops pll_lock before each new request. The one go_set it issues mid-sequence is the deliberate R5 case, and the checks expect it to have no effect.

// File: rtl/pll_go_pkg.sv
package pll_go_pkg;

   typedef enum logic [2:0] {
      S_IDLE      = 3'd0,
      S_WAIT_FP   = 3'd1,
      S_INIT      = 3'd2,
      S_EN        = 3'd3,
      S_EN_DIV    = 3'd4,
      S_WAIT_LOCK = 3'd5,
      S_DONE      = 3'd6
   } seq_state_e;

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

   function automatic int unsigned bits_for(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

endpackage

// File: rtl/pll_go_lock_sync.sv
module pll_go_lock_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lock_in,
   output logic lock_out
);

   generate
      if (STAGES > 3) begin : g_bad
         $error("pll_go_lock_sync: STAGES must be 0 to 3");
      end

      if (STAGES == 0) begin : g_direct
         assign lock_out = lock_in;
      end else begin : g_chain
         logic [STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_q <= '0;
            end else if (STAGES == 1) begin
               sync_q <= lock_in;
            end else begin
               sync_q <= {sync_q[STAGES-2:0], lock_in};
            end
         end
         assign lock_out = sync_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pll_go_cfg_regs.sv
module pll_go_cfg_regs #(
   parameter int unsigned MULT_W   = 11,
   parameter int unsigned PREDIV_W = 7,
   parameter int unsigned HSDIV_W  = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                stg_we,
   input  logic [MULT_W-1:0]   stg_mult,
   input  logic [PREDIV_W-1:0] stg_prediv,
   input  logic [HSDIV_W-1:0]  stg_hsdiv,
   input  logic                load_shadow,
   output logic [MULT_W-1:0]   shd_mult,
   output logic [PREDIV_W-1:0] shd_prediv,
   output logic [HSDIV_W-1:0]  shd_hsdiv
);

   localparam int unsigned CFG_W = MULT_W + PREDIV_W + HSDIV_W;

   logic [CFG_W-1:0] stage_q;
   logic [CFG_W-1:0] shadow_q;

   // staging is written freely; shadow copies it as one word on load
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else if (stg_we) begin
         stage_q <= {stg_mult, stg_prediv, stg_hsdiv};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
      end else if (load_shadow) begin
         shadow_q <= stage_q;
      end
   end

   assign shd_mult   = shadow_q[CFG_W-1 -: MULT_W];
   assign shd_prediv = shadow_q[HSDIV_W +: PREDIV_W];
   assign shd_hsdiv  = shadow_q[HSDIV_W-1:0];

endmodule

// File: rtl/pll_go_fsm.sv
module pll_go_fsm
   import pll_go_pkg::*;
#(
   parameter int unsigned T_INIT   = 4,
   parameter int unsigned T_EN     = 3,
   parameter int unsigned T_DIV    = 2,
   parameter int unsigned LOCK_TMO = 40
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go_set,
   input  logic       auto_mode,
   input  logic       fp_strobe,
   input  logic       lock_s,
   output seq_state_e state,
   output logic       mode_q,
   output logic       go_bit,
   output logic       lock_err,
   output logic       load_shadow,
   output logic       init_n,
   output logic       pll_en,
   output logic       div_en,
   output logic       locking
);

   localparam int unsigned MAX_T = max4(T_INIT, T_EN, T_DIV, LOCK_TMO);
   localparam int unsigned CNT_W = bits_for(MAX_T);

   seq_state_e        state_q, state_d;
   logic [CNT_W-1:0]  cnt_q;
   logic              cnt_zero;
   logic              accept;
   logic              timeout;

   assign cnt_zero = (cnt_q == '0);
   assign accept   = (state_q == S_IDLE) && go_set;
   assign timeout  = (state_q == S_WAIT_LOCK) && !lock_s && cnt_zero;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         S_IDLE:      if (go_set) state_d = auto_mode ? S_WAIT_FP : S_INIT;
         S_WAIT_FP:   if (fp_strobe) state_d = S_INIT;
         S_INIT:      if (cnt_zero) state_d = S_EN;
         S_EN:        if (cnt_zero) state_d = S_EN_DIV;
         S_EN_DIV:    if (cnt_zero) state_d = S_WAIT_LOCK;
         S_WAIT_LOCK: if (lock_s || cnt_zero) state_d = S_DONE;
         S_DONE:      state_d = S_IDLE;
         default:     state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   // phase counter reloads on every state entry
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (state_d != state_q) begin
         unique case (state_d)
            S_INIT:      cnt_q <= CNT_W'(T_INIT - 1);
            S_EN:        cnt_q <= CNT_W'(T_EN - 1);
            S_EN_DIV:    cnt_q <= CNT_W'(T_DIV - 1);
            S_WAIT_LOCK: cnt_q <= CNT_W'(LOCK_TMO - 1);
            default:     cnt_q <= '0;
         endcase
      end else if (!cnt_zero) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         go_bit <= 1'b0;
         mode_q <= 1'b0;
      end else if (accept) begin
         go_bit <= 1'b1;
         mode_q <= auto_mode;
      end else if (state_q == S_DONE) begin
         go_bit <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_err <= 1'b0;
      end else if (accept) begin
         lock_err <= 1'b0;
      end else if (timeout) begin
         lock_err <= 1'b1;
      end
   end

   // enables stay on after the sequence; only an init phase drops them
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pll_en <= 1'b0;
         div_en <= 1'b0;
      end else if (state_d != state_q) begin
         if (state_d == S_INIT) begin
            pll_en <= 1'b0;
            div_en <= 1'b0;
         end
         if (state_d == S_EN)     pll_en <= 1'b1;
         if (state_d == S_EN_DIV) div_en <= 1'b1;
      end
   end

   assign load_shadow = (state_d == S_INIT) && (state_q != S_INIT);
   assign init_n      = (state_q != S_INIT);
   assign locking     = (state_q == S_INIT) || (state_q == S_EN) ||
                        (state_q == S_EN_DIV) || (state_q == S_WAIT_LOCK);
   assign state       = state_q;

endmodule

// File: rtl/pll_go_ovr.sv
module pll_go_ovr (
   input  logic hw_own,
   input  logic locking,
   input  logic sw_clkin_en,
   input  logic sw_div_bypass,
   input  logic sw_ref_en,
   output logic clkin_en,
   output logic div_bypass,
   output logic ref_en
);

   always_comb begin
      if (hw_own) begin
         clkin_en   = !locking;
         div_bypass = locking;
         ref_en     = 1'b1;
      end else begin
         clkin_en   = sw_clkin_en;
         div_bypass = sw_div_bypass;
         ref_en     = sw_ref_en;
      end
   end

endmodule

// File: rtl/pll_go_seq.sv
module pll_go_seq
   import pll_go_pkg::*;
#(
   parameter int unsigned MULT_W      = 11,
   parameter int unsigned PREDIV_W    = 7,
   parameter int unsigned HSDIV_W     = 4,
   parameter int unsigned T_INIT      = 4,
   parameter int unsigned T_EN        = 3,
   parameter int unsigned T_DIV       = 2,
   parameter int unsigned LOCK_TMO    = 40,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                stg_we,
   input  logic [MULT_W-1:0]   stg_mult,
   input  logic [PREDIV_W-1:0] stg_prediv,
   input  logic [HSDIV_W-1:0]  stg_hsdiv,
   input  logic                go_set,
   input  logic                auto_mode,
   input  logic                fp_strobe,
   input  logic                pll_lock,
   input  logic                sw_clkin_en,
   input  logic                sw_div_bypass,
   input  logic                sw_ref_en,
   output logic                go_bit,
   output logic                busy,
   output logic                lock_err,
   output logic                pll_init_n,
   output logic                pll_en,
   output logic                pll_div_en,
   output logic [MULT_W-1:0]   shd_mult,
   output logic [PREDIV_W-1:0] shd_prediv,
   output logic [HSDIV_W-1:0]  shd_hsdiv,
   output logic                clkin_en,
   output logic                div_bypass,
   output logic                ref_en
);

   localparam int unsigned CFG_W = MULT_W + PREDIV_W + HSDIV_W;

   generate
      if (MULT_W < 1 || PREDIV_W < 1 || HSDIV_W < 1) begin : g_bad_w
         $error("pll_go_seq: field widths must be at least 1");
      end
      if (T_INIT < 1 || T_EN < 1 || T_DIV < 1 || LOCK_TMO < 1) begin : g_bad_t
         $error("pll_go_seq: phase lengths must be at least 1");
      end
   endgenerate

   seq_state_e seq_state;
   logic       mode_q;
   logic       lock_s;
   logic       load_shadow;
   logic       locking;
   logic       hw_own;

   pll_go_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .lock_in  (pll_lock),
      .lock_out (lock_s)
   );

   pll_go_fsm #(
      .T_INIT   (T_INIT),
      .T_EN     (T_EN),
      .T_DIV    (T_DIV),
      .LOCK_TMO (LOCK_TMO)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .go_set      (go_set),
      .auto_mode   (auto_mode),
      .fp_strobe   (fp_strobe),
      .lock_s      (lock_s),
      .state       (seq_state),
      .mode_q      (mode_q),
      .go_bit      (go_bit),
      .lock_err    (lock_err),
      .load_shadow (load_shadow),
      .init_n      (pll_init_n),
      .pll_en      (pll_en),
      .div_en      (pll_div_en),
      .locking     (locking)
   );

   pll_go_cfg_regs #(
      .MULT_W   (MULT_W),
      .PREDIV_W (PREDIV_W),
      .HSDIV_W  (HSDIV_W)
   ) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .stg_we      (stg_we),
      .stg_mult    (stg_mult),
      .stg_prediv  (stg_prediv),
      .stg_hsdiv   (stg_hsdiv),
      .load_shadow (load_shadow),
      .shd_mult    (shd_mult),
      .shd_prediv  (shd_prediv),
      .shd_hsdiv   (shd_hsdiv)
   );

   assign busy   = (seq_state != S_IDLE);
   // mode is frozen for a running sequence, live otherwise
   assign hw_own = busy ? mode_q : auto_mode;

   pll_go_ovr u_ovr (
      .hw_own        (hw_own),
      .locking       (locking),
      .sw_clkin_en   (sw_clkin_en),
      .sw_div_bypass (sw_div_bypass),
      .sw_ref_en     (sw_ref_en),
      .clkin_en      (clkin_en),
      .div_bypass    (div_bypass),
      .ref_en        (ref_en)
   );

endmodule

// File: rtl/pll_go_seq_chk.sv
module pll_go_seq_chk
   import pll_go_pkg::*;
#(
   parameter int unsigned CFG_W = 22
) (
   input logic             clk,
   input logic             rst_n,
   input logic             go_set,
   input logic             auto_mode,
   input logic             sw_clkin_en,
   input logic             sw_div_bypass,
   input logic             sw_ref_en,
   input logic             go_bit,
   input logic             busy,
   input logic             lock_err,
   input logic             pll_init_n,
   input logic             pll_en,
   input logic             pll_div_en,
   input logic [CFG_W-1:0] shadow,
   input logic             clkin_en,
   input logic             div_bypass,
   input logic             ref_en,
   input seq_state_e       state
);

   // R2: accepted request raises GO and busy on the next cycle
   a_r2_go_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && go_set) |=> (busy && go_bit));

   // R3: enables are low throughout the init pulse
   a_r3_init_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !pll_init_n |-> (!pll_en && !pll_div_en));

   // R3: divider enable never without the PLL enable
   a_r3_div_after_en: assert property (@(posedge clk) disable iff (!rst_n)
      pll_div_en |-> pll_en);

   // R4: no init pulse while waiting for the front porch
   a_r4_hold_for_fp: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_WAIT_FP) |-> (pll_init_n && $stable(shadow)));

   // R6: GO clears exactly when the sequence leaves busy
   a_r6_go_tracks_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !go_bit);

   // R7: error rises only at the end of a sequence
   a_r7_err_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_err) |=> $fell(busy));

   // R8: manual idle controls follow software
   a_r8_manual_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_mode && !busy) |->
         (clkin_en == sw_clkin_en && div_bypass == sw_div_bypass && ref_en == sw_ref_en));

   // R9: automatic idle controls are owned by hardware
   a_r9_auto_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_mode && !busy) |-> (clkin_en && !div_bypass && ref_en));

   // R10: idle shadow is stable without a request
   a_r10_idle_shadow: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !go_set) |=> $stable(shadow));

endmodule

bind pll_go_seq pll_go_seq_chk #(.CFG_W(MULT_W + PREDIV_W + HSDIV_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .go_set        (go_set),
   .auto_mode     (auto_mode),
   .sw_clkin_en   (sw_clkin_en),
   .sw_div_bypass (sw_div_bypass),
   .sw_ref_en     (sw_ref_en),
   .go_bit        (go_bit),
   .busy          (busy),
   .lock_err      (lock_err),
   .pll_init_n    (pll_init_n),
   .pll_en        (pll_en),
   .pll_div_en    (pll_div_en),
   .shadow        ({shd_mult, shd_prediv, shd_hsdiv}),
   .clkin_en      (clkin_en),
   .div_bypass    (div_bypass),
   .ref_en        (ref_en),
   .state         (seq_state)
);

// File: tb/pll_go_seq_tb.sv
module pll_go_seq_tb;

   localparam int MW = 11;
   localparam int PW = 7;
   localparam int HW = 4;
   localparam int TI = 4;
   localparam int TE = 3;
   localparam int TD = 2;
   localparam int TMO = 40;
   localparam int WD_CYCLES = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          stg_we = 1'b0;
   logic [MW-1:0] stg_mult = '0;
   logic [PW-1:0] stg_prediv = '0;
   logic [HW-1:0] stg_hsdiv = '0;
   logic          go_set = 1'b0;
   logic          auto_mode = 1'b0;
   logic          fp_strobe = 1'b0;
   logic          pll_lock = 1'b0;
   logic          sw_clkin_en = 1'b0;
   logic          sw_div_bypass = 1'b0;
   logic          sw_ref_en = 1'b0;
   logic          go_bit, busy, lock_err, pll_init_n, pll_en, pll_div_en;
   logic [MW-1:0] shd_mult;
   logic [PW-1:0] shd_prediv;
   logic [HW-1:0] shd_hsdiv;
   logic          clkin_en, div_bypass, ref_en;

   int n_checks = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   pll_go_seq u_dut (
      .clk(clk), .rst_n(rst_n), .stg_we(stg_we), .stg_mult(stg_mult),
      .stg_prediv(stg_prediv), .stg_hsdiv(stg_hsdiv), .go_set(go_set),
      .auto_mode(auto_mode), .fp_strobe(fp_strobe), .pll_lock(pll_lock),
      .sw_clkin_en(sw_clkin_en), .sw_div_bypass(sw_div_bypass), .sw_ref_en(sw_ref_en),
      .go_bit(go_bit), .busy(busy), .lock_err(lock_err), .pll_init_n(pll_init_n),
      .pll_en(pll_en), .pll_div_en(pll_div_en), .shd_mult(shd_mult),
      .shd_prediv(shd_prediv), .shd_hsdiv(shd_hsdiv), .clkin_en(clkin_en),
      .div_bypass(div_bypass), .ref_en(ref_en)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] shd_word();
      return 32'({shd_mult, shd_prediv, shd_hsdiv});
   endfunction

   task automatic stage(input logic [MW-1:0] m, input logic [PW-1:0] p, input logic [HW-1:0] h);
      @(negedge clk);
      stg_we = 1'b1; stg_mult = m; stg_prediv = p; stg_hsdiv = h;
      @(negedge clk);
      stg_we = 1'b0;
   endtask

   task automatic pulse_go();
      @(negedge clk);
      go_set = 1'b1;
      @(negedge clk);
      go_set = 1'b0;
   endtask

   // waits for busy to drop with a bound; returns cycles waited
   task automatic wait_idle(output int n);
      n = 0;
      while (busy && n < 200) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic t_reset();
      check(go_bit == 0 && busy == 0 && lock_err == 0, "R1", "flags", {go_bit, busy, lock_err}, 0);
      check(pll_init_n == 1 && pll_en == 0 && pll_div_en == 0, "R1", "pins",
            {pll_init_n, pll_en, pll_div_en}, 3'b100);
      check(shd_word() == 0, "R1", "shadow", shd_word(), 0);
   endtask

   task automatic t_manual_seq();
      int n;
      logic [31:0] exp_w;
      exp_w = 32'({11'h2a5, 7'h33, 4'h9});
      auto_mode = 0; sw_clkin_en = 0; sw_div_bypass = 1; sw_ref_en = 1;
      stage(11'h2a5, 7'h33, 4'h9);
      // R10: idle staging write leaves shadow alone
      check(shd_word() == 0, "R10", "shadow before go", shd_word(), 0);
      pll_lock = 0;
      pulse_go();
      check(go_bit && busy, "R2", "go/busy after accept", {go_bit, busy}, 2'b11);
      check(!pll_init_n, "R2", "init low", pll_init_n, 0);
      check(shd_word() == exp_w, "R2", "shadow loaded", shd_word(), exp_w);
      check(clkin_en == 0 && div_bypass == 1 && ref_en == 1, "R8", "manual pass busy",
            {clkin_en, div_bypass, ref_en}, 3'b011);
      n = 0;
      while (!pll_init_n && n < 50) begin n++; @(negedge clk); end
      check(n == TI, "R3", "init width", n, TI);
      n = 0;
      while (pll_en && !pll_div_en && n < 50) begin n++; @(negedge clk); end
      check(n == TE, "R3", "enable-only width", n, TE);
      check(pll_en && pll_div_en, "R3", "div enable after", {pll_en, pll_div_en}, 2'b11);
      pll_lock = 1;
      wait_idle(n);
      check(!go_bit && !busy, "R6", "go cleared", {go_bit, busy}, 0);
      check(pll_en && pll_div_en, "R6", "enables held", {pll_en, pll_div_en}, 2'b11);
      check(!lock_err, "R6", "no error", lock_err, 0);
      sw_clkin_en = 1; sw_div_bypass = 0; sw_ref_en = 0;
      @(negedge clk);
      check(clkin_en == 1 && div_bypass == 0 && ref_en == 0, "R8", "manual pass idle",
            {clkin_en, div_bypass, ref_en}, 3'b100);
   endtask

   task automatic t_auto_seq();
      int n;
      logic [31:0] old_w, exp_w;
      old_w = shd_word();
      exp_w = 32'({11'h0f1, 7'h05, 4'h3});
      auto_mode = 1; sw_clkin_en = 1; sw_div_bypass = 0; sw_ref_en = 0;
      stage(11'h0f1, 7'h05, 4'h3);
      @(negedge clk);
      check(clkin_en == 1 && div_bypass == 0 && ref_en == 1, "R9", "auto idle",
            {clkin_en, div_bypass, ref_en}, 3'b101);
      pll_lock = 0;
      pulse_go();
      repeat (5) @(negedge clk);
      check(busy && pll_init_n, "R4", "waits for strobe", {busy, pll_init_n}, 2'b11);
      check(shd_word() == old_w, "R4", "shadow held", shd_word(), old_w);
      fp_strobe = 1;
      @(negedge clk);
      fp_strobe = 0;
      check(!pll_init_n, "R4", "init after strobe", pll_init_n, 0);
      check(shd_word() == exp_w, "R4", "shadow after strobe", shd_word(), exp_w);
      check(clkin_en == 0 && div_bypass == 1 && ref_en == 1, "R9", "auto locking",
            {clkin_en, div_bypass, ref_en}, 3'b011);
      n = 0;
      while (!pll_div_en && n < 50) begin n++; @(negedge clk); end
      check(clkin_en == 0 && div_bypass == 1, "R9", "auto locking div phase",
            {clkin_en, div_bypass}, 2'b01);
      pll_lock = 1;
      wait_idle(n);
      check(!go_bit && !busy, "R6", "auto go cleared", {go_bit, busy}, 0);
      check(clkin_en == 1 && div_bypass == 0 && ref_en == 1, "R9", "auto restored",
            {clkin_en, div_bypass, ref_en}, 3'b101);
      auto_mode = 0;
   endtask

   task automatic t_busy_ignore();
      int n;
      int lows;
      bit was_low;
      logic [31:0] first_w, second_w;
      first_w  = 32'({11'h111, 7'h11, 4'h1});
      second_w = 32'({11'h7ee, 7'h6e, 4'he});
      auto_mode = 0; pll_lock = 0;
      stage(11'h111, 7'h11, 4'h1);
      pulse_go();
      while (!pll_init_n) @(negedge clk);
      // now in enable phase: restage and re-request
      stg_we = 1; stg_mult = 11'h7ee; stg_prediv = 7'h6e; stg_hsdiv = 4'he; go_set = 1;
      @(negedge clk);
      stg_we = 0; go_set = 0;
      check(shd_word() == first_w, "R5", "shadow kept mid-run", shd_word(), first_w);
      lows = 0; was_low = 0; n = 0;
      while (!pll_div_en && n < 50) begin
         if (!pll_init_n) was_low = 1;
         n++; @(negedge clk);
      end
      pll_lock = 1;
      while (busy && n < 200) begin
         if (!pll_init_n) was_low = 1;
         n++; @(negedge clk);
      end
      lows = was_low ? 1 : 0;
      check(lows == 0, "R5", "no restart", lows, 0);
      check(!busy && shd_word() == first_w, "R5", "shadow after run", shd_word(), first_w);
      pll_lock = 0;
      pulse_go();
      check(shd_word() == second_w, "R5", "next go loads restaged", shd_word(), second_w);
      pll_lock = 1;
      wait_idle(n);
   endtask

   task automatic t_timeout();
      int n;
      auto_mode = 0; pll_lock = 0;
      @(negedge clk);
      pulse_go();
      n = 0;
      while (busy && n < 500) begin n++; @(negedge clk); end
      check(n == TI + TE + TD + TMO + 1, "R7", "busy length", n, TI + TE + TD + TMO + 1);
      check(lock_err && !go_bit, "R7", "error set, go clear", {lock_err, go_bit}, 2'b10);
      repeat (3) @(negedge clk);
      check(lock_err, "R7", "error sticky", lock_err, 1);
      pulse_go();
      check(!lock_err, "R7", "error cleared by go", lock_err, 0);
      pll_lock = 1;
      wait_idle(n);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_manual_seq();
      t_auto_seq();
      t_busy_ignore();
      t_timeout();
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule